// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is a transmit DMA engine. It reads a ring of 8-byte buffer descriptors from memory, starting at a given pointer. Each descriptor names a data buffer by pointer and byte length. The engine gathers the buffers that make up one frame and sends the frame out, one byte at a time, on a valid/ready stream. It marks the final byte with an end-of-frame flag. After a descriptor has been consumed, the engine writes it back with its status bits cleared. Descriptors that carry an interrupt flag raise a one-cycle event.

Software fills the descriptors, sets the ring base, the start pointer, the upper address bits and the byte order, and then pulses `kick`. The walk stops when the next descriptor address would be the ring base again. At that point the block parks its current pointer at the base and sets the halt bit for this ring. Frames that are too short can be padded with zero bytes up to 64 bytes.

Top module: `tx_ring_walker`

## Requirements
- R1: Byte A of a memory word sits in bits [31-8*(A mod 4) -: 8]. In big-endian mode, descriptor word 0 holds the flags in bits [31:16] and the length in [15:0], and word 1 (offset 4) is the buffer pointer. Flag bits: ready 15, pad 14, wrap 13, interrupt 12, last 11.
- R2: When `littleEndian` is 1, each 16-bit field of word 0 is byte-swapped and the pointer word is fully byte-reversed. This applies to both reads and write-back.
- R3: The low 3 bits of `ringBase` and of `startPtr` are ignored. Every memory address carries `addrHi` in bits [35:32].
- R4: A descriptor whose ready bit is 0 is neither streamed nor written. A ready descriptor with length 0 is skipped with no data, no write and no event.
- R5: Buffers are streamed in ring order, starting at any byte alignment. `txLast` is asserted only on the final byte of the frame, which ends at a descriptor with the last bit set.
- R6: If `padEnable` is 1, or the pad bit of the first descriptor of the frame is set, a frame shorter than 64 bytes is followed by zero bytes up to 64. `txLast` then falls on byte 64.
- R7: After write-back of a descriptor with the interrupt bit set, `evtFrame` pulses if that descriptor had the last bit, and `evtBuffer` pulses otherwise.
- R8: Write-back of word 0 keeps the length and flag bits 14..10 and 6. It clears bits 15, 9..7 and 5..0.
- R9: The next descriptor is 8 bytes on, or the ring base when the wrap bit is set. When that address equals the base, the walk ends: `curPtr` equals the base and `haltStatus` bit 31-RING_ID is set. A new walk clears the halt bit.
- R10: A `kick` while `txEnable` is 0 starts nothing: there are no memory requests and no writes.
- R11: `memReq` is held with a stable address until `memRspValid`. While `txReady` is 0, `txValid` stays high and `txData` and `txLast` stay stable.
- R12: After reset, `busy`, `memReq`, `txValid` and the events are 0, and `haltStatus` and `curPtr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Transmit enable, sampled at kick |
| littleEndian | input | 1 | Descriptor byte order select |
| padEnable | input | 1 | Global short-frame pad enable |
| kick | input | 1 | Start a walk |
| ringBase | input | 32 | Ring base address, low bits 31:0 |
| startPtr | input | 32 | First descriptor address |
| addrHi | input | 4 | Address bits 35:32 |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 36 | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memRspValid | input | 1 | Request completed; read data valid |
| memRdata | input | 32 | Read data |
| txValid | output | 1 | Stream byte valid |
| txData | output | 8 | Stream byte |
| txLast | output | 1 | End-of-frame marker |
| txReady | input | 1 | Stream sink ready |
| evtFrame | output | 1 | Frame interrupt event pulse |
| evtBuffer | output | 1 | Buffer interrupt event pulse |
| haltStatus | output | 32 | Ring halt bits |
| curPtr | output | 32 | Current descriptor pointer |
| busy | output | 1 | Walk in progress |

## Verification
Some properties are checked on every cycle. The memory and stream handshakes hold steady under back-pressure, and the ready bit is clear in every write-back word in both byte orders. A walk never begins without transmit enable. A frame event coincides with an emptied frame counter, and the halt bit only rises with the pointer parked at the base. Other behaviour is shown only by the bench's scenarios: the byte order of gathered buffers, unaligned starts, zero padding and its final marker, the exact written-back descriptor words, skipped and zero-length descriptors, and the wrap point.

// File: rtl/tx_walk_pkg.sv
package tx_walk_pkg;
  localparam int FLAG_READY = 15;
  localparam int FLAG_PAD   = 14;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_INTR  = 12;
  localparam int FLAG_LAST  = 11;
  // ready, defer, late collision, retry limit, retry count, underrun, truncation
  localparam logic [15:0] WB_CLEAR = 16'h83BF;
  localparam int FIELD_W = 16;

  typedef enum logic [1:0] {SEL_DESC0, SEL_DESC1, SEL_DATA} addrSel_e;

  typedef struct packed {
    addrSel_e addrSel;
    logic     padPhase;
    logic     loadStart;
    logic     capWord0;
    logic     capWord1;
    logic     capData;
    logic     emitByte;
    logic     emitPad;
    logic     frameEnd;
    logic     advance;
    logic     finish;
    logic     raiseFrame;
    logic     raiseBuffer;
  } walkCtl_t;

  typedef struct packed {
    logic descReady;
    logic descLast;
    logic descIntr;
    logic lenZero;
    logic lastInDesc;
    logic wordEnd;
    logic padPend;
    logic padLast;
    logic atBase;
  } walkStat_t;

  function automatic logic [31:0] swapInHalves(input logic [31:0] w);
    return {w[23:16], w[31:24], w[7:0], w[15:8]};
  endfunction

  function automatic logic [31:0] reverseBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/tx_walk_ctrl.sv
module tx_walk_ctrl
  import tx_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      kick,
  input  logic      txEnable,
  input  logic      memRspValid,
  input  logic      txReady,
  input  walkStat_t stat,
  output walkCtl_t  ctl,
  output logic      memReq,
  output logic      memWe,
  output logic      txValid,
  output logic      busy
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_CHK, ST_RD1, ST_DRD, ST_EMIT, ST_PAD, ST_WB, ST_ADV
  } walkState_e;

  walkState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = SEL_DESC0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    txValid     = 1'b0;
    nextState   = state;
    unique case (state)
      ST_IDLE: if (kick && txEnable) begin
        ctl.loadStart = 1'b1;
        nextState     = ST_RD0;
      end
      ST_RD0: begin
        memReq = 1'b1;
        if (memRspValid) begin
          ctl.capWord0 = 1'b1;
          nextState    = ST_CHK;
        end
      end
      ST_CHK: nextState = stat.descReady ? ST_RD1 : ST_ADV;
      ST_RD1: begin
        memReq      = 1'b1;
        ctl.addrSel = SEL_DESC1;
        if (memRspValid) begin
          ctl.capWord1 = 1'b1;
          nextState    = stat.lenZero ? ST_ADV : ST_DRD;
        end
      end
      ST_DRD: begin
        memReq      = 1'b1;
        ctl.addrSel = SEL_DATA;
        if (memRspValid) begin
          ctl.capData = 1'b1;
          nextState   = ST_EMIT;
        end
      end
      ST_EMIT: begin
        txValid = 1'b1;
        if (txReady) begin
          ctl.emitByte = 1'b1;
          if (stat.lastInDesc) nextState = stat.padPend ? ST_PAD : ST_WB;
          else if (stat.wordEnd) nextState = ST_DRD;
        end
      end
      ST_PAD: begin
        txValid      = 1'b1;
        ctl.padPhase = 1'b1;
        if (txReady) begin
          ctl.emitPad = 1'b1;
          if (stat.padLast) nextState = ST_WB;
        end
      end
      ST_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memRspValid) begin
          ctl.frameEnd    = stat.descLast;
          ctl.raiseFrame  = stat.descIntr && stat.descLast;
          ctl.raiseBuffer = stat.descIntr && !stat.descLast;
          nextState       = ST_ADV;
        end
      end
      ST_ADV: begin
        ctl.advance = 1'b1;
        if (stat.atBase) begin
          ctl.finish = 1'b1;
          nextState  = ST_IDLE;
        end else begin
          nextState = ST_RD0;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  assert_start_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txEnable));
endmodule

// File: rtl/tx_walk_dp.sv
module tx_walk_dp
  import tx_walk_pkg::*;
#(
  parameter int ADDR_HI_W = 4,
  parameter int MIN_FRAME = 64,
  parameter int RING_ID   = 0,
  parameter int FRAME_W   = 17
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  walkCtl_t                ctl,
  input  logic                    littleEndian,
  input  logic                    padEnable,
  input  logic [31:0]             ringBase,
  input  logic [31:0]             startPtr,
  input  logic [ADDR_HI_W-1:0]    addrHi,
  input  logic [31:0]             memRdata,
  output walkStat_t               stat,
  output logic [32+ADDR_HI_W-1:0] memAddr,
  output logic [31:0]             memWdata,
  output logic [7:0]              txData,
  output logic                    txLast,
  output logic                    evtFrame,
  output logic                    evtBuffer,
  output logic [31:0]             haltStatus,
  output logic [31:0]             curPtr
);
  localparam int HALT_BIT = 31 - RING_ID;
  localparam logic [FRAME_W-1:0] PAD_LAST  = FRAME_W'(MIN_FRAME - 1);
  localparam logic [FRAME_W:0]   MIN_WIDE  = (FRAME_W + 1)'(MIN_FRAME);

  logic [31:0]         baseAddr, descAddr, byteAddr, dataWord, nextDesc;
  logic [FIELD_W-1:0]  flagsReg, lenReg, remain;
  logic [FRAME_W-1:0]  frameCount;
  logic                firstPad, padPend, haltReg;
  logic [31:0]         word0In, wbWord;
  logic [FRAME_W:0]    frameSum;
  logic                padOnNow;
  logic [7:0]          laneByte;

  assign word0In  = littleEndian ? swapInHalves(memRdata) : memRdata;
  assign nextDesc = flagsReg[FLAG_WRAP] ? baseAddr : descAddr + 32'd8;
  assign frameSum = {1'b0, frameCount} + {{(FRAME_W + 1 - FIELD_W){1'b0}}, lenReg};
  assign padOnNow = padEnable || ((frameCount == '0) ? flagsReg[FLAG_PAD] : firstPad);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr   <= '0;
      descAddr   <= '0;
      byteAddr   <= '0;
      dataWord   <= '0;
      flagsReg   <= '0;
      lenReg     <= '0;
      remain     <= '0;
      frameCount <= '0;
      firstPad   <= 1'b0;
      padPend    <= 1'b0;
      haltReg    <= 1'b0;
      evtFrame   <= 1'b0;
      evtBuffer  <= 1'b0;
    end else begin
      evtFrame  <= ctl.raiseFrame;
      evtBuffer <= ctl.raiseBuffer;
      if (ctl.loadStart) begin
        baseAddr <= {ringBase[31:3], 3'b000};
        descAddr <= {startPtr[31:3], 3'b000};
        haltReg  <= 1'b0;
      end
      if (ctl.capWord0) begin
        flagsReg <= word0In[31:16];
        lenReg   <= word0In[15:0];
      end
      if (ctl.capWord1) begin
        byteAddr <= littleEndian ? reverseBytes(memRdata) : memRdata;
        remain   <= lenReg;
        if (frameCount == '0) firstPad <= flagsReg[FLAG_PAD];
        padPend  <= flagsReg[FLAG_LAST] && padOnNow && (frameSum < MIN_WIDE);
      end
      if (ctl.capData) dataWord <= memRdata;
      if (ctl.emitByte) begin
        byteAddr   <= byteAddr + 32'd1;
        remain     <= remain - 1'b1;
        frameCount <= frameCount + 1'b1;
      end
      if (ctl.emitPad)  frameCount <= frameCount + 1'b1;
      if (ctl.frameEnd) frameCount <= '0;
      if (ctl.advance)  descAddr   <= nextDesc;
      if (ctl.finish)   haltReg    <= 1'b1;
    end
  end

  always_comb begin
    unique case (byteAddr[1:0])
      2'd0:    laneByte = dataWord[31:24];
      2'd1:    laneByte = dataWord[23:16];
      2'd2:    laneByte = dataWord[15:8];
      default: laneByte = dataWord[7:0];
    endcase
  end

  always_comb begin
    unique case (ctl.addrSel)
      SEL_DESC1: memAddr = {addrHi, descAddr[31:3], 3'b100};
      SEL_DATA:  memAddr = {addrHi, byteAddr[31:2], 2'b00};
      default:   memAddr = {addrHi, descAddr};
    endcase
  end

  assign wbWord   = {flagsReg & ~WB_CLEAR, lenReg};
  assign memWdata = littleEndian ? swapInHalves(wbWord) : wbWord;
  assign txData   = ctl.padPhase ? 8'h00 : laneByte;
  assign txLast   = ctl.padPhase ? (frameCount == PAD_LAST)
                                 : (flagsReg[FLAG_LAST] && remain == 16'd1 && !padPend);

  assign stat.descReady  = flagsReg[FLAG_READY];
  assign stat.descLast   = flagsReg[FLAG_LAST];
  assign stat.descIntr   = flagsReg[FLAG_INTR];
  assign stat.lenZero    = (lenReg == '0);
  assign stat.lastInDesc = (remain == 16'd1);
  assign stat.wordEnd    = (byteAddr[1:0] == 2'd3);
  assign stat.padPend    = padPend;
  assign stat.padLast    = (frameCount == PAD_LAST);
  assign stat.atBase     = (nextDesc == baseAddr);

  assign haltStatus = {31'd0, haltReg} << HALT_BIT;
  assign curPtr     = descAddr;

  assert_halt_at_base_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReg) |-> (descAddr == baseAddr));
  assert_frame_evt_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    evtFrame |-> (frameCount == '0));
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import tx_walk_pkg::*;
#(
  parameter int ADDR_HI_W = 4,
  parameter int MIN_FRAME = 64,
  parameter int RING_ID   = 0,
  parameter int FRAME_W   = 17
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    txEnable,
  input  logic                    littleEndian,
  input  logic                    padEnable,
  input  logic                    kick,
  input  logic [31:0]             ringBase,
  input  logic [31:0]             startPtr,
  input  logic [ADDR_HI_W-1:0]    addrHi,
  output logic                    memReq,
  output logic                    memWe,
  output logic [32+ADDR_HI_W-1:0] memAddr,
  output logic [31:0]             memWdata,
  input  logic                    memRspValid,
  input  logic [31:0]             memRdata,
  output logic                    txValid,
  output logic [7:0]              txData,
  output logic                    txLast,
  input  logic                    txReady,
  output logic                    evtFrame,
  output logic                    evtBuffer,
  output logic [31:0]             haltStatus,
  output logic [31:0]             curPtr,
  output logic                    busy
);
  walkCtl_t  ctl;
  walkStat_t stat;

  tx_walk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .kick(kick), .txEnable(txEnable),
    .memRspValid(memRspValid), .txReady(txReady), .stat(stat), .ctl(ctl),
    .memReq(memReq), .memWe(memWe), .txValid(txValid), .busy(busy)
  );

  tx_walk_dp #(
    .ADDR_HI_W(ADDR_HI_W), .MIN_FRAME(MIN_FRAME), .RING_ID(RING_ID), .FRAME_W(FRAME_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .littleEndian(littleEndian),
    .padEnable(padEnable), .ringBase(ringBase), .startPtr(startPtr),
    .addrHi(addrHi), .memRdata(memRdata), .stat(stat), .memAddr(memAddr),
    .memWdata(memWdata), .txData(txData), .txLast(txLast),
    .evtFrame(evtFrame), .evtBuffer(evtBuffer), .haltStatus(haltStatus),
    .curPtr(curPtr)
  );

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRspValid |=> memReq && $stable(memAddr) && $stable(memWe));
  assert_stream_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast));
  assert_wb_ready_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> (littleEndian ? !memWdata[23] : !memWdata[31]));
endmodule

// File: tb/tx_ring_walker_tb_top.sv
module tx_ring_walker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b1, littleEndian = 1'b0, padEnable = 1'b0, kick = 1'b0;
  logic [31:0] ringBase = '0, startPtr = '0;
  logic [3:0]  addrHi = 4'hA;
  logic memReq, memWe, memRspValid, txValid, txLast, txReady, evtFrame, evtBuffer, busy;
  logic [35:0] memAddr;
  logic [31:0] memWdata, memRdata, haltStatus, curPtr;
  logic [7:0]  txData;

  always #5 clk = ~clk;

  tx_ring_walker dut_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .littleEndian(littleEndian),
    .padEnable(padEnable), .kick(kick), .ringBase(ringBase), .startPtr(startPtr),
    .addrHi(addrHi), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRspValid(memRspValid), .memRdata(memRdata),
    .txValid(txValid), .txData(txData), .txLast(txLast), .txReady(txReady),
    .evtFrame(evtFrame), .evtBuffer(evtBuffer), .haltStatus(haltStatus),
    .curPtr(curPtr), .busy(busy)
  );

  int checks = 0, errors = 0;
  int reqCount = 0, addrBad = 0, frameEvts = 0, bufEvts = 0, cyc = 0;
  logic [31:0] mem [256];
  logic [8:0]  expQ [$];

  // memory model: one outstanding request, one wait cycle
  logic memBusy = 1'b0;
  logic [1:0] memLat = '0;
  always @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0; memBusy <= 1'b0; memRdata <= '0;
    end else if (memRspValid) begin
      memRspValid <= 1'b0; memBusy <= 1'b0;
    end else if (memReq && !memBusy) begin
      memBusy <= 1'b1; memLat <= 2'd1; reqCount <= reqCount + 1;
      if (memAddr[35:32] != addrHi) addrBad <= addrBad + 1;
    end else if (memBusy) begin
      if (memLat != 0) memLat <= memLat - 1'b1;
      else begin
        memRspValid <= 1'b1;
        if (memWe) mem[memAddr[9:2]] <= memWdata;
        else memRdata <= mem[memAddr[9:2]];
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // stream sink with back-pressure and scoreboard monitor
  always @(negedge clk) begin
    cyc <= cyc + 1;
    txReady = (cyc % 5) != 3;
    if (rstN && evtFrame) frameEvts++;
    if (rstN && evtBuffer) bufEvts++;
    if (rstN && txValid && txReady) begin
      if (expQ.size() == 0) check("R5 unexpected byte", {55'd0, txLast, txData}, 64'h1FF);
      else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check("R5/R6 stream byte", {55'd0, txLast, txData}, {55'd0, e});
      end
    end
  end

  function automatic logic [7:0] byteAt(input int a);
    return mem[a >> 2][31 - 8*(a % 4) -: 8];
  endfunction

  function automatic logic [7:0] fill(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic putDesc(input int a, input logic [15:0] fl, input logic [15:0] ln,
                         input logic [31:0] ptr, input logic le);
    mem[a >> 2]     = le ? tx_walk_pkg::swapInHalves({fl, ln}) : {fl, ln};
    mem[(a >> 2)+1] = le ? tx_walk_pkg::reverseBytes(ptr) : ptr;
  endtask

  task automatic pushData(input int a, input int n, input logic endsFrame);
    for (int i = 0; i < n; i++) expQ.push_back({endsFrame && (i == n-1), byteAt(a + i)});
  endtask

  task automatic pushPad(input int n);
    for (int i = 0; i < n; i++) expQ.push_back({i == n-1, 8'h00});
  endtask

  task automatic runWalk(input logic [31:0] base, input logic [31:0] start);
    @(negedge clk);
    ringBase = base; startPtr = start; kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    if (txEnable) check("R9 halt cleared at start", {32'd0, haltStatus}, 64'd0);
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fe, be, rc;
    for (int w = 0; w < 256; w++)
      mem[w] = {fill(4*w), fill(4*w+1), fill(4*w+2), fill(4*w+3)};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 busy", {63'd0, busy}, 0);
    check("R12 memReq", {63'd0, memReq}, 0);
    check("R12 txValid", {63'd0, txValid}, 0);
    check("R12 events", {62'd0, evtFrame, evtBuffer}, 0);
    check("R12 halt", {32'd0, haltStatus}, 0);
    check("R12 curPtr", {32'd0, curPtr}, 0);

    // Test A: big-endian, two buffers, unaligned start, misaligned base/start (R1 R3 R5 R7 R8 R9)
    putDesc(32'h40, 16'h93FF, 16'd5,  32'h101, 1'b0);
    putDesc(32'h48, 16'h9C00, 16'd70, 32'h200, 1'b0);
    putDesc(32'h50, 16'h2000, 16'd4,  32'h300, 1'b0);
    pushData(32'h101, 5, 1'b0);
    pushData(32'h200, 70, 1'b1);
    fe = frameEvts; be = bufEvts;
    runWalk(32'h43, 32'h45);
    check("R5 queue drained A", 64'(expQ.size()), 0);
    check("R8 wb desc0 flags cleared", {32'd0, mem[16]}, {32'd0, 32'h1040_0005});
    check("R8 wb desc1 keeps bit 10", {32'd0, mem[18]}, {32'd0, 32'h1C00_0046});
    check("R4 not-ready desc untouched", {32'd0, mem[20]}, {32'd0, 32'h2000_0004});
    check("R7 buffer event", 64'(bufEvts - be), 1);
    check("R7 frame event", 64'(frameEvts - fe), 1);
    check("R9 curPtr at base", {32'd0, curPtr}, 64'h40);
    check("R9 halt bit 31", {32'd0, haltStatus}, 64'h8000_0000);
    check("R3 upper address bits", 64'(addrBad), 0);

    // Test B: little-endian, pad flag in descriptor, zero-length descriptor (R2 R4 R6)
    littleEndian = 1'b1;
    putDesc(32'h80, 16'hC800, 16'd10, 32'h302, 1'b1);
    putDesc(32'h88, 16'hA000, 16'd0,  32'h380, 1'b1);
    pushData(32'h302, 10, 1'b0);
    pushPad(54);
    fe = frameEvts; be = bufEvts;
    runWalk(32'h80, 32'h80);
    check("R6 queue drained B", 64'(expQ.size()), 0);
    check("R2 LE write-back word", {32'd0, mem[32]}, {32'd0, 32'h0048_0A00});
    check("R4 zero-length desc unchanged", {32'd0, mem[34]},
          {32'd0, tx_walk_pkg::swapInHalves(32'hA000_0000)});
    check("R7 no events without interrupt bit", 64'((frameEvts - fe) + (bufEvts - be)), 0);
    check("R9 curPtr B", {32'd0, curPtr}, 64'h80);

    // Test C: global pad, start mid-ring, wrap back to base (R6 R9 R4)
    littleEndian = 1'b0; padEnable = 1'b1;
    putDesc(32'hC0, 16'h0000, 16'd3,  32'h3C0, 1'b0);
    putDesc(32'hC8, 16'h8000, 16'd6,  32'h203, 1'b0);
    putDesc(32'hD0, 16'hA800, 16'd14, 32'h250, 1'b0);
    pushData(32'h203, 6, 1'b0);
    pushData(32'h250, 14, 1'b0);
    pushPad(44);
    runWalk(32'hC0, 32'hC8);
    check("R6 queue drained C", 64'(expQ.size()), 0);
    check("R9 wrap ends walk at base", {32'd0, curPtr}, 64'hC0);
    check("R4 skipped desc before start unchanged", {32'd0, mem[48]}, {32'd0, 32'h0000_0003});
    check("R8 wb desc C1", {32'd0, mem[50]}, {32'd0, 32'h0000_0006});
    check("R8 wb desc C2", {32'd0, mem[52]}, {32'd0, 32'h2800_000E});
    padEnable = 1'b0;

    // Test D: transmit disabled (R10)
    txEnable = 1'b0;
    putDesc(32'h40, 16'h9800, 16'd8, 32'h101, 1'b0);
    rc = reqCount;
    runWalk(32'h40, 32'h40);
    repeat (10) @(negedge clk);
    check("R10 no memory requests", 64'(reqCount - rc), 0);
    check("R10 busy stays low", {63'd0, busy}, 0);
    check("R10 desc unchanged", {32'd0, mem[16]}, {32'd0, 32'h9800_0008});
    check("R10 no stream bytes", 64'(expQ.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule